// File: doc/BRIEF.md
# Per-Sector Error Count Reducer

After a page has been decoded, a status memory holds one small corrected-bit count for every sector of that page. Several counts share one memory word. This block walks those counts for a requested number of sectors and reduces them to three figures. The first is the total number of corrected bits. The second is the number of sectors that could not be corrected. The third is the largest count found in any correctable sector.

A sector whose field holds the all-ones value is uncorrectable. It adds one to the failure count and takes no part in the sum or the maximum. The block reads one status word per sector through a read port with one cycle of latency, which suits an inferred block RAM. It handles one sector per clock and raises a one-cycle done flag once the last sector has been folded in. The field width, the distance between fields, the number of fields per word and the largest sector count are all parameters.

Top module: `sector_err_reducer`

## Requirements
- R1: After reset, done, rd_en and all three results are zero.
- R2: Sector i is read from word i/FPW (defaults: FPW=4) at bit offset (i mod FPW)*FIELD_STEP (default 8). Only the low FIELD_W bits (default 6) at that offset form the count, and higher bits in the step are ignored. Exactly one read cycle (rd_en high) is issued per sector, and addresses start at 0 and ascend.
- R3: A field equal to all ones (63 by default) increments fail_cnt and changes neither corr_total nor max_flips.
- R4: Every other field is added to corr_total.
- R5: max_flips is the largest field among the correctable sectors only.
- R6: An accepted start clears all three results, so no total carries over from an earlier scan.
- R7: For N>0 sectors, done is high for exactly one cycle, following the (N+1)th rising edge after the edge that samples start. The results are final while done is high.
- R8: For N=0, done is high for one cycle right after the edge that samples start, all results are zero and no read is issued.
- R9: A start pulse that arrives while a scan is still reading or folding is ignored, and the running scan finishes with its own timing and results.
- R10: rd_data is taken one cycle after the matching rd_en/rd_addr cycle, so a synchronous-read memory can be attached directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| sector_cnt | input | SECT_W (5) | Number of sectors to scan, 0 to MAX_SECT |
| rd_en | output | 1 | Read enable for the status memory |
| rd_addr | output | ADDR_W (2) | Status word address |
| rd_data | input | WORD_W (32) | Status word, one cycle after the read |
| corr_total | output | SUM_W (11) | Sum of correctable sector counts |
| fail_cnt | output | SECT_W (5) | Number of uncorrectable sectors |
| max_flips | output | FIELD_W (6) | Largest correctable sector count |
| done | output | 1 | One-cycle scan-complete flag |

## Verification
A lane counter that drifts out of step with the word address picks the wrong field. This shows up in corr_total or max_flips at the very next done. A stale remaining-count register moves done away from edge N+1 and changes the number of rd_en cycles. Both show within one scan. A missing clear on start leaves the previous totals in place, so a zero-sector scan right after a busy one reports nonzero results at once.

// File: rtl/serr_pkg.sv
package serr_pkg;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/serr_walker.sv
module serr_walker
  import serr_pkg::*;
#(
  parameter int unsigned FPW    = 4,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SECT_W = 5,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SECT_W-1:0] sector_cnt,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              vld_q,
  output logic              last_q,
  output logic [LANE_W-1:0] lane_q,
  output logic              clr,
  output logic              zero_req
);

  walk_state_e       state;
  logic [SECT_W-1:0] remain;
  logic [LANE_W-1:0] lane;
  logic [ADDR_W-1:0] addr;
  logic              accept;

  // a scan is in flight while reading or while the last word is still being folded
  assign accept   = start && (state == WK_IDLE) && !vld_q;
  assign clr      = accept;
  assign zero_req = accept && (sector_cnt == '0);
  assign rd_en    = (state == WK_RUN);
  assign rd_addr  = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WK_IDLE;
      remain <= '0;
      lane   <= '0;
      addr   <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      lane_q <= '0;
    end else begin
      vld_q  <= rd_en;
      last_q <= rd_en && (remain == SECT_W'(1));
      lane_q <= lane;
      if (accept && (sector_cnt != '0)) begin
        state  <= WK_RUN;
        remain <= sector_cnt;
        lane   <= '0;
        addr   <= '0;
      end else if (state == WK_RUN) begin
        remain <= remain - SECT_W'(1);
        if (remain == SECT_W'(1)) begin
          state <= WK_IDLE;
        end
        if (lane == LANE_W'(FPW - 1)) begin
          lane <= '0;
          addr <= addr + ADDR_W'(1);
        end else begin
          lane <= lane + LANE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/serr_field_pick.sv
module serr_field_pick #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIELD_W    = 6,
  parameter int unsigned FIELD_STEP = 8,
  parameter int unsigned FPW        = 4,
  parameter int unsigned LANE_W     = 2
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [LANE_W-1:0]  lane,
  output logic [FIELD_W-1:0] field,
  output logic               bad
);

  logic [FIELD_W-1:0] lanes [FPW];

  for (genvar g = 0; g < FPW; g++) begin : g_lane
    assign lanes[g] = word[g*FIELD_STEP +: FIELD_W];
  end

  always_comb begin
    field = '0;
    for (int i = 0; i < FPW; i++) begin
      if (lane == LANE_W'(i)) begin
        field = lanes[i];
      end
    end
  end

  assign bad = &field;

endmodule

// File: rtl/serr_accum.sv
module serr_accum #(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned SECT_W  = 5,
  parameter int unsigned SUM_W   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               zero_req,
  input  logic               vld,
  input  logic               last,
  input  logic [FIELD_W-1:0] field,
  input  logic               bad,
  output logic [SUM_W-1:0]   corr_total,
  output logic [SECT_W-1:0]  fail_cnt,
  output logic [FIELD_W-1:0] max_flips,
  output logic               done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_total <= '0;
      fail_cnt   <= '0;
      max_flips  <= '0;
      done       <= 1'b0;
    end else begin
      done <= zero_req || (vld && last);
      if (clr) begin
        corr_total <= '0;
        fail_cnt   <= '0;
        max_flips  <= '0;
      end else if (vld) begin
        if (bad) begin
          fail_cnt <= fail_cnt + SECT_W'(1);
        end else begin
          corr_total <= corr_total + SUM_W'(field);
          if (field > max_flips) begin
            max_flips <= field;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sector_err_reducer.sv
module sector_err_reducer
  import serr_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIELD_W    = 6,
  parameter int unsigned FIELD_STEP = 8,
  parameter int unsigned FPW        = 4,
  parameter int unsigned MAX_SECT   = 16,
  localparam int unsigned SECT_W    = bits_for(MAX_SECT + 1),
  localparam int unsigned NWORDS    = (MAX_SECT + FPW - 1) / FPW,
  localparam int unsigned ADDR_W    = bits_for(NWORDS),
  localparam int unsigned SUM_W     = FIELD_W + SECT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SECT_W-1:0]  sector_cnt,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0]  rd_data,
  output logic [SUM_W-1:0]   corr_total,
  output logic [SECT_W-1:0]  fail_cnt,
  output logic [FIELD_W-1:0] max_flips,
  output logic               done
);

  localparam int unsigned LANE_W = bits_for(FPW);

  logic              vld_q;
  logic              last_q;
  logic [LANE_W-1:0] lane_q;
  logic              clr;
  logic              zero_req;
  logic [FIELD_W-1:0] field;
  logic              bad;

  serr_walker #(
    .FPW(FPW), .ADDR_W(ADDR_W), .SECT_W(SECT_W), .LANE_W(LANE_W)
  ) walker_i (
    .clk(clk), .rst(rst), .start(start), .sector_cnt(sector_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .vld_q(vld_q), .last_q(last_q),
    .lane_q(lane_q), .clr(clr), .zero_req(zero_req)
  );

  serr_field_pick #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .FIELD_STEP(FIELD_STEP),
    .FPW(FPW), .LANE_W(LANE_W)
  ) pick_i (
    .word(rd_data), .lane(lane_q), .field(field), .bad(bad)
  );

  serr_accum #(
    .FIELD_W(FIELD_W), .SECT_W(SECT_W), .SUM_W(SUM_W)
  ) accum_i (
    .clk(clk), .rst(rst), .clr(clr), .zero_req(zero_req), .vld(vld_q),
    .last(last_q), .field(field), .bad(bad), .corr_total(corr_total),
    .fail_cnt(fail_cnt), .max_flips(max_flips), .done(done)
  );

endmodule

// File: rtl/serr_checker.sv
module serr_checker #(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned SUM_W   = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [SUM_W-1:0]   corr_total,
  input logic [FIELD_W-1:0] max_flips,
  input logic               done
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en); // R7

  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (rd_addr == '0)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |->
      ((rd_addr == $past(rd_addr)) || (rd_addr == $past(rd_addr) + ADDR_W'(1)))); // R2

  AST_MAX_IN_SUM: assert property (@(posedge clk) disable iff (rst)
    SUM_W'(max_flips) <= corr_total); // R5

endmodule

bind sector_err_reducer serr_checker #(
  .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SUM_W(SUM_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .corr_total(corr_total), .max_flips(max_flips), .done(done)
);

// File: tb/sector_err_reducer_tb_top.sv
module sector_err_reducer_tb_top;

  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  sector_cnt = '0;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data = '0;
  logic [10:0] corr_total;
  logic [4:0]  fail_cnt;
  logic [5:0]  max_flips;
  logic        done;

  logic [31:0] mem [NW];
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  // one-cycle synchronous read, R10
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  sector_err_reducer dut_i (
    .clk(clk), .rst(rst), .start(start), .sector_cnt(sector_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .corr_total(corr_total), .fail_cnt(fail_cnt), .max_flips(max_flips),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_of(input int n, output int s, output int f, output int m);
    s = 0; f = 0; m = 0;
    for (int i = 0; i < n; i++) begin
      int v;
      v = int'((mem[i/4] >> ((i % 4) * 8)) & 32'h3F);
      if (v == 63) f++;
      else begin
        s += v;
        if (v > m) m = v;
      end
    end
  endtask

  // inject < 0: no extra start; otherwise a start of 1 sector at that index
  task automatic run_scan(input int n, input int inject, input string req);
    int es, ef, em, first, rds, exp_idx;
    int cs, cf, cm;
    expect_of(n, es, ef, em);
    exp_idx = (n == 0) ? 0 : n + 1;
    first = -1; rds = 0; cs = 0; cf = 0; cm = 0;
    @(negedge clk);
    sector_cnt = 5'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n + 6; k++) begin
      if (k > 0) @(negedge clk);
      if (k == inject) begin
        sector_cnt = 5'd1;
        start = 1'b1;
      end else if (k == inject + 1) begin
        start = 1'b0;
      end
      if (rd_en) rds++;
      if (first >= 0 && k == first + 1)
        chk(!done, "R7", {req, " done single cycle"}, int'(done), 0);
      if (done && first < 0) begin
        first = k;
        cs = int'(corr_total); cf = int'(fail_cnt); cm = int'(max_flips);
      end
    end
    chk(first == exp_idx, (n == 0) ? "R8" : "R7", {req, " done timing"}, first, exp_idx);
    chk(cs == es, "R4", {req, " corr_total"}, cs, es);
    chk(cf == ef, "R3", {req, " fail_cnt"}, cf, ef);
    chk(cm == em, "R5", {req, " max_flips"}, cm, em);
    chk(rds == n, (n == 0) ? "R8" : "R2", {req, " read cycles"}, rds, n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !rd_en, "R1", "done/rd_en after reset", int'(done) + int'(rd_en), 0);
    chk(corr_total == 0 && fail_cnt == 0 && max_flips == 0, "R1",
        "results after reset", int'(corr_total) + int'(fail_cnt) + int'(max_flips), 0);
  endtask

  task automatic t_clean();
    // all correctable, data arrives through the one-cycle port (R10)
    mem[0] = 32'h0A031105; mem[1] = 32'h01020304; mem[2] = 32'h0; mem[3] = 32'h0;
    run_scan(5, -1, "R10 clean5");
  endtask

  task automatic t_mixed();
    // all-ones fields excluded from sum and max (R3, R5)
    mem[0] = 32'h3F3E013F; mem[1] = 32'h07003F10;
    run_scan(8, -1, "R3 mixed8");
  endtask

  task automatic t_zero_after();
    // R6: zero-sector scan right after a busy one must report zeros
    run_scan(0, -1, "R6 zero");
  endtask

  task automatic t_full_masked();
    // R2: bits above the field inside each step are ignored
    mem[0] = 32'hC5FF4181; mem[1] = 32'h80C0FFBE;
    mem[2] = 32'h7F3F0102; mem[3] = 32'hE0112233;
    run_scan(16, -1, "R2 full16");
  endtask

  task automatic t_restart_ignored();
    mem[0] = 32'h04050607; mem[1] = 32'h3F3F0809;
    run_scan(6, 2, "R9 busy start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_mixed();
    t_zero_after();
    t_full_masked();
    t_restart_ignored();
    t_clean();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule